// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a 32-pin input port and raises one interrupt line toward the processor when any pin meets the condition software chose for it. Each pin owns a control word whose 4-bit mode field picks one of six behaviours: off, active-low level, active-high level, rising edge, falling edge or any edge. Pin inputs are first brought into the clock domain by a synchronizer chain. An edge is found by comparing the synchronized value with the value it had one cycle before.

Detected events set sticky per-pin bits in a shared flag word. Software reads that word to find the source and clears bits by writing ones. The interrupt output is a registered OR of every flag bit. A simple single-cycle register bus gives access to the control words and the flag word. Reads return data one cycle after the read strobe.

Each pin runs a small detection-mode decoder: an enumerated mode (DET_OFF, DET_LOW, DET_RISE, DET_FALL, DET_BOTH, DET_HIGH) selected by the field code through a unique case. The mode is a pure decode with no transitions of its own. A pin moves between modes only when software rewrites its control word.

Top module: `gpirq_top`

## Requirements
- R1: After reset every mode field and every flag bit is zero, `irq_out` is low and `bus_rdata` is zero.
- R2: The control word of pin n sits at byte offset 4*n, with the mode field in bits 19:16. A read returns the field there and zero in all other bits. Writes to unaligned offsets, or to offsets outside the control area other than the flag word, change no state.
- R3: Mode code 0x0 and every code outside the list below never set a flag, whatever the pin does.
- R4: Code 0x8 sets the flag on every cycle the synchronized pin is 0, and code 0xC on every cycle it is 1. A clear issued while the level persists is undone on the next cycle.
- R5: Code 0x9 flags a 0-to-1 change, 0xA a 1-to-0 change and 0xB either change. A change is the synchronized value differing from its value one cycle earlier.
- R6: The flag word is at byte offset 0xA0 and holds bit n for pin n.
- R7: Writing the flag word clears each bit written as 1 and leaves each bit written as 0 untouched. Writing all ones clears every flag.
- R8: When a clear and a new event for the same pin land in the same cycle, the flag stays set.
- R9: `irq_out` is a register holding the OR of the flag bits one cycle earlier. A pin change driven before clock edge k sets its flag at edge k+2 and `irq_out` at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous pin levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions watch, on every cycle, several rules. A flag never rises under a disabled or unlisted code. A set flag survives any cycle in which its bit was not written as one. A held level under codes 0x8 or 0xC, or a rising step under 0x9, always sets the flag on the next edge. The interrupt never rises without a flag behind it. Only the bench's scenarios can show other properties: exact read-back contents, the two-stage input latency, that an ignored write truly left the state alone, and that a clear timed onto an edge event loses.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    localparam int unsigned CFG_W   = 4;
    localparam int unsigned CFG_LSB = 16;

    localparam logic [CFG_W-1:0] CODE_OFF  = 4'h0;
    localparam logic [CFG_W-1:0] CODE_LOW  = 4'h8;
    localparam logic [CFG_W-1:0] CODE_RISE = 4'h9;
    localparam logic [CFG_W-1:0] CODE_FALL = 4'hA;
    localparam logic [CFG_W-1:0] CODE_BOTH = 4'hB;
    localparam logic [CFG_W-1:0] CODE_HIGH = 4'hC;

    typedef enum logic [2:0] {
        DET_OFF  = 3'd0,
        DET_LOW  = 3'd1,
        DET_RISE = 3'd2,
        DET_FALL = 3'd3,
        DET_BOTH = 3'd4,
        DET_HIGH = 3'd5
    } det_mode_e;

    // Map a raw field code onto a detection mode; unknown codes disable.
    function automatic det_mode_e decode_cfg(input logic [CFG_W-1:0] code);
        det_mode_e m;
        unique case (code)
            CODE_LOW:  m = DET_LOW;
            CODE_RISE: m = DET_RISE;
            CODE_FALL: m = DET_FALL;
            CODE_BOTH: m = DET_BOTH;
            CODE_HIGH: m = DET_HIGH;
            default:   m = DET_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpirq_pin_detect.sv
module gpirq_pin_detect
    import gpirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             lvl,
    output logic             hit
);

    logic      prev_q;
    det_mode_e mode;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign mode = decode_cfg(cfg);

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            DET_OFF:  hit = 1'b0;
            DET_LOW:  hit = ~lvl;
            DET_RISE: hit = lvl & ~prev_q;
            DET_FALL: hit = ~lvl & prev_q;
            DET_BOTH: hit = lvl ^ prev_q;
            DET_HIGH: hit = lvl;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpirq_flags.sv
module gpirq_flags #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] flags,
    output logic             irq
);

    logic [WIDTH-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_mask : '0;

    // A new event is ORed after the clear, so it wins a same-cycle race.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= (flags & ~clr_eff) | hit;
            irq   <= |flags;
        end
    end

endmodule

// File: rtl/gpirq_top.sv
module gpirq_top
    import gpirq_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FLAG_OFS    = 'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    localparam int unsigned IDX_W     = ADDR_W - 2;
    localparam int unsigned CTRL_SPAN = NUM_PINS * 4;

    logic [NUM_PINS-1:0]            sync_q;
    logic [NUM_PINS-1:0]            hit;
    logic [NUM_PINS-1:0]            flag_q;
    logic [NUM_PINS-1:0][CFG_W-1:0] cfg_q;
    logic [IDX_W-1:0]               idx;
    logic                           ctrl_sel;
    logic                           flag_sel;
    logic [DATA_W-1:0]              rd_next;

    assign idx      = bus_addr[ADDR_W-1:2];
    assign ctrl_sel = (int'(bus_addr) < int'(CTRL_SPAN)) && (bus_addr[1:0] == 2'b00);
    assign flag_sel = (bus_addr == ADDR_W'(FLAG_OFS));

    gpirq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[i] <= CODE_OFF;
            else if (bus_wr && ctrl_sel && (idx == IDX_W'(i)))
                cfg_q[i] <= bus_wdata[CFG_LSB +: CFG_W];
        end

        gpirq_pin_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg_q[i]),
            .lvl   (sync_q[i]),
            .hit   (hit[i])
        );
    end

    gpirq_flags #(
        .WIDTH (NUM_PINS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .clr_en   (bus_wr && flag_sel),
        .clr_mask (bus_wdata[NUM_PINS-1:0]),
        .flags    (flag_q),
        .irq      (irq_out)
    );

    always_comb begin
        rd_next = '0;
        if (flag_sel) begin
            rd_next[NUM_PINS-1:0] = flag_q;
        end else if (ctrl_sel) begin
            for (int k = 0; k < NUM_PINS; k++) begin
                if (idx == IDX_W'(k)) rd_next[CFG_LSB +: CFG_W] = cfg_q[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/gpirq_checker.sv
module gpirq_checker #(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned FLAG_OFS = 'hA0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      irq_out,
    input logic [NUM_PINS-1:0][3:0]  cfg_q,
    input logic [NUM_PINS-1:0]       sync_q,
    input logic [NUM_PINS-1:0]       flag_q
);

    logic [NUM_PINS-1:0] wmask;
    assign wmask = (bus_wr && bus_addr == ADDR_W'(FLAG_OFS)) ? bus_wdata[NUM_PINS-1:0] : '0;

    // R1: leaving reset starts with no flag and a quiet line
    p_clean_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_q == '0 && !irq_out));

    // R2: control reads carry data only in the mode field
    p_ctrl_read_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) < int'(NUM_PINS * 4)) |=> ((bus_rdata & ~32'h000F_0000) == '0));

    // R7: a set flag survives unless its bit was written as one
    p_hold_unless_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((flag_q | $past(wmask)) & $past(flag_q)) == $past(flag_q)));

    // R9: the line never rises without a flag behind it
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($past(flag_q) != '0));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        // R3: only listed codes may raise a flag
        p_valid_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> ($past(cfg_q[i]) >= 4'h8 && $past(cfg_q[i]) <= 4'hC));

        // R4: a held level under a level code always sets the flag (R8: even against a clear)
        p_level_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_q[i] == 4'hC && sync_q[i]) || (cfg_q[i] == 4'h8 && !sync_q[i])) |=> flag_q[i]);

        // R5: a rising step under the rising code sets the flag
        p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[i] == 4'h9 && sync_q[i] && !$past(sync_q[i])) |=> flag_q[i]);
    end

endmodule

bind gpirq_top gpirq_checker #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FLAG_OFS (FLAG_OFS)
) i_gpirq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .cfg_q     (cfg_q),
    .sync_q    (sync_q),
    .flag_q    (flag_q)
);

// File: tb/test_gpirq_top.sv
`timescale 1ns/1ps
module test_gpirq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pins;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out;

    always #10 clk = ~clk;

    gpirq_top i_gpirq_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Behavioural reference model
    logic [31:0] m_s1, m_s2, m_prev, m_flags, m_rdata, m_hits, m_clr;
    logic        m_irq;
    logic [3:0]  m_cfg [32];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_flags = '0; m_rdata = '0; m_irq = 1'b0;
            for (int p = 0; p < 32; p++) m_cfg[p] = 4'h0;
        end else begin
            for (int p = 0; p < 32; p++) begin
                m_hits[p] = (m_cfg[p] == 4'h8 && !m_s2[p]) ||
                            (m_cfg[p] == 4'hC &&  m_s2[p]) ||
                            (m_cfg[p] == 4'h9 &&  m_s2[p] && !m_prev[p]) ||
                            (m_cfg[p] == 4'hA && !m_s2[p] &&  m_prev[p]) ||
                            (m_cfg[p] == 4'hB && (m_s2[p] != m_prev[p]));
            end
            if (bus_rd) begin
                if (bus_addr == 8'hA0) m_rdata = m_flags;
                else if (bus_addr < 8'd128 && bus_addr[1:0] == 2'b00)
                    m_rdata = {12'h000, m_cfg[bus_addr / 4], 16'h0000};
                else m_rdata = '0;
            end
            m_clr   = (bus_wr && bus_addr == 8'hA0) ? bus_wdata : '0;
            m_irq   = (m_flags != '0);
            m_flags = (m_flags & ~m_clr) | m_hits;
            if (bus_wr && bus_addr < 8'd128 && bus_addr[1:0] == 2'b00)
                m_cfg[bus_addr / 4] = bus_wdata[19:16];
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pins;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && chk_on && !done) begin
            check({cur_tag, " irq_out"}, {31'd0, irq_out}, {31'd0, m_irq});
            check({cur_tag, " bus_rdata"}, bus_rdata, m_rdata);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pins = 32'h0000_0010;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; chk_on = 1'b1;

        // R1: reset state
        cur_tag = "R1";
        check("R1 irq", {31'd0, irq_out}, 32'd0);
        rd(8'hA0); check("R1 flags", bus_rdata, 32'h0);
        rd(8'h00); check("R1 ctrl0", bus_rdata, 32'h0);

        // R2: field placement, ignored writes
        cur_tag = "R2";
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04); check("R2 readback", bus_rdata, 32'h000F_0000);
        wr(8'h06, 32'h000C_0000);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h04); check("R2 unaligned ignored", bus_rdata, 32'h000F_0000);
        rd(8'h08); check("R2 neighbour untouched", bus_rdata, 32'h0);

        // R3: unlisted code 0xF on pin 1, code 0 on pin 6
        cur_tag = "R3";
        wr(8'h18, 32'h0000_0000);
        pins[1] = 1'b1; pins[6] = 1'b1; idle(3);
        pins[1] = 1'b0; pins[6] = 1'b0; idle(3);
        pins[1] = 1'b1; idle(4);
        rd(8'hA0); check("R3 no flag", bus_rdata, 32'h0);
        check("R3 irq quiet", {31'd0, irq_out}, 32'd0);

        // R5 / R6: edge modes
        cur_tag = "R5";
        wr(8'h00, 32'h0009_0000);
        wr(8'h08, 32'h000A_0000);
        wr(8'h0C, 32'h000B_0000);
        pins[0] = 1'b1; idle(5);
        rd(8'hA0); check("R5 rising pin0 (R6 bit0)", bus_rdata, 32'h1);
        pins[0] = 1'b0; idle(5);
        rd(8'hA0); check("R5 no flag on fall", bus_rdata, 32'h1);

        // R7: write-zero no effect, write-one clears
        cur_tag = "R7";
        wr(8'hA0, 32'h0); rd(8'hA0); check("R7 zero write", bus_rdata, 32'h1);
        wr(8'hA0, 32'h1); rd(8'hA0); check("R7 one clears", bus_rdata, 32'h0);

        cur_tag = "R5";
        pins[2] = 1'b1; idle(5);
        rd(8'hA0); check("R5 falling ignores rise", bus_rdata, 32'h0);
        pins[2] = 1'b0; idle(5);
        rd(8'hA0); check("R5 falling pin2", bus_rdata, 32'h4);
        pins[3] = 1'b1; idle(5);
        rd(8'hA0); check("R5 either rise pin3", bus_rdata, 32'hC);
        cur_tag = "R7";
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0); check("R7 all ones", bus_rdata, 32'h0);
        cur_tag = "R5";
        pins[3] = 1'b0; idle(5);
        rd(8'hA0); check("R5 either fall pin3", bus_rdata, 32'h8);

        // R8: clear lands on the edge event cycle
        cur_tag = "R8";
        pins[3] = 1'b1; idle(2);
        wr(8'hA0, 32'h8);
        rd(8'hA0); check("R8 event beats clear", bus_rdata, 32'h8);
        wr(8'hA0, 32'h8);
        rd(8'hA0); check("R8 later clear works", bus_rdata, 32'h0);

        // R4: level modes
        cur_tag = "R4";
        wr(8'h10, 32'h0008_0000);
        wr(8'h14, 32'h000C_0000);
        pins[5] = 1'b1; idle(5);
        rd(8'hA0); check("R4 high level", bus_rdata, 32'h20);
        wr(8'hA0, 32'h20);
        rd(8'hA0); check("R4 clear undone", bus_rdata, 32'h20);
        pins[5] = 1'b0; idle(4);
        wr(8'hA0, 32'h20);
        rd(8'hA0); check("R4 clear after level gone", bus_rdata, 32'h0);
        pins[4] = 1'b0; idle(5);
        rd(8'hA0); check("R4 low level", bus_rdata, 32'h10);
        pins[4] = 1'b1; idle(4);
        wr(8'hA0, 32'h10);
        rd(8'hA0); check("R4 low cleared", bus_rdata, 32'h0);

        // R9: latency of flag and line
        cur_tag = "R9";
        idle(3);
        check("R9 idle line", {31'd0, irq_out}, 32'd0);
        pins[0] = 1'b1;
        idle(3);
        check("R9 line not yet", {31'd0, irq_out}, 32'd0);
        idle(1);
        check("R9 line raised", {31'd0, irq_out}, 32'd1);
        wr(8'hA0, 32'hFFFF_FFFF);
        idle(2);
        check("R9 line dropped", {31'd0, irq_out}, 32'd0);

        idle(2);
        finish_run();
    end

endmodule